// File: doc/BRIEF.md
# Calendar and Time-of-Day Counter

This block keeps wall-clock time and the calendar date. Seconds, minutes, hours, day of week, day of month, month, two-digit year and a century byte sit behind a small register window. A host writes and reads them through a select code. Once per second an external strobe moves the whole calendar forward by one second. All carries, from seconds up to the century load, settle in the clock cycle in which the strobe is sampled.

A control register sets how the host sees the values. One bit selects binary or packed BCD. A second bit selects 24-hour or 12-hour hours, where 12-hour mode flags PM in bit 7. A third bit turns on rule-based daylight-saving jumps. A fourth bit freezes the count so the host can load a new time without a tick landing partway through. The counter holds its state in binary and converts to and from the selected format at the register window. Month lengths and leap years, including the century rule, are worked out internally.

Top module: `civil_clock`

## Requirements
- R1: A synchronous active-low reset sets the time to 00:00:00, day of week 1, day of month 1, month 1, year 0 and the century byte to 8'h20.
- R2: Register select codes are 0 seconds, 1 minutes, 2 hours, 3 day of week, 4 day of month, 5 month, 6 year, 7 century and 8 control. Control bit 0 = 1 means binary and 0 means packed BCD (tens in [7:4], units in [3:0]). The selected format applies to both reads and writes of codes 0 to 6. Codes above 8 read as 0.
- R3: Control bit 1 = 1 gives hours 0 to 23. With bit 1 = 0, the hours register shows 1 to 12 in bits [6:0], with midnight and noon as 12, and bit 7 = 1 for hours 12 to 23. Writes in that mode are decoded the same way.
- R4: When the strobe is sampled, the seconds advance by one. Carries into minutes, hours, day, month and year resolve in that same cycle, so the next read shows the new values.
- R5: Months 1, 3, 5, 7, 8, 10 and 12 have 31 days, months 4, 6, 9 and 11 have 30, and February has 28 unless R6 applies. After the last day, the count moves to day 1 of the next month, and month 12 wraps to month 1.
- R6: February has 29 days when the year is non-zero and divisible by 4, or when the year is 0 and the century value (decoded in the current data format) is divisible by 4.
- R7: When the year wraps from 99 to 0, century bits [6:0] load 7'h20 and bit 7 keeps its previous value.
- R8: Day of week counts 1 to 7, advances at each day rollover, and wraps from 7 to 1. Value 1 is Sunday.
- R9: With control bit 2 = 1, a strobe at 01:59:59 on a Sunday (day of week 1) in month 4 with day of month 1 to 7 moves the time to 03:00:00.
- R10: With control bit 2 = 1, the first strobe at 01:59:59 on a Sunday in month 10 with day of month 25 or later moves the time to 01:00:00. The next time 01:59:59 is reached that day, counting continues to 02:00:00.
- R11: While control bit 3 is 1, strobes have no effect on any time or calendar register.
- R12: A host write to any of codes 0 to 7 in the same cycle as a strobe takes the written value, and that strobe is dropped.
- R13: Reset does not change control bits 0 to 3. They change only through host writes to code 8.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick | input | 1 | One-second update strobe, one cycle wide |
| wr_en | input | 1 | Host write enable |
| wr_sel | input | 4 | Host write register select |
| wr_data | input | 8 | Host write data |
| rd_sel | input | 4 | Host read register select |
| rd_data | output | 8 | Read data for rd_sel, combinational |

## Verification
The bench sweeps every hour value through all four format combinations, in both directions. A wrong 12-hour mapping would show midnight as 0 or lose the PM flag at noon. It walks every month to its last day in both data formats, and tests February across the century rules. A design that used one month-length table, or applied the divisible-by-4 rule to 2100, would land on the wrong day. The year 99 wrap is checked with both values of the century top bit, which catches a design that clobbers bit 7. The daylight-saving tests include the off-window Sunday and the repeated 01:59:59 in autumn; a design without the one-shot flag would loop in the repeated hour for ever.

// File: rtl/cal_pkg.sv
// Package: shared time record, register select codes and format helpers.
// Assumes values in binary are below 100 when converted to BCD.
package cal_pkg;

    typedef struct packed {
        logic [6:0] sec;
        logic [6:0] min;
        logic [6:0] hour;
        logic [2:0] dow;
        logic [4:0] dom;
        logic [3:0] mon;
        logic [6:0] year;
    } cal_time_t;

    localparam logic [3:0] SEL_SEC  = 4'd0;
    localparam logic [3:0] SEL_MIN  = 4'd1;
    localparam logic [3:0] SEL_HOUR = 4'd2;
    localparam logic [3:0] SEL_DOW  = 4'd3;
    localparam logic [3:0] SEL_DOM  = 4'd4;
    localparam logic [3:0] SEL_MON  = 4'd5;
    localparam logic [3:0] SEL_YEAR = 4'd6;
    localparam logic [3:0] SEL_CENT = 4'd7;
    localparam logic [3:0] SEL_CTL  = 4'd8;

    // Binary 0..99 to packed BCD.
    function automatic logic [7:0] bin2bcd(input logic [6:0] v);
        logic [6:0] tens;
        logic [6:0] ones;
        tens = v / 7'd10;
        ones = v % 7'd10;
        return {tens[3:0], ones[3:0]};
    endfunction

    // Packed BCD to binary.
    function automatic logic [6:0] bcd2bin(input logic [7:0] b);
        return ({3'b000, b[7:4]} * 7'd10) + {3'b000, b[3:0]};
    endfunction

endpackage

// File: rtl/cal_month_len.sv
// Month length: days in the current month, with the full leap-year rule.
// Assumes year is binary 0..99 and century is already decoded to binary.
module cal_month_len (
    input  logic [3:0] mon,
    input  logic [6:0] year,
    input  logic [6:0] cent,
    output logic [4:0] days
);
    logic leap;

    // Leap test: year 0 defers to the century, otherwise divisible by 4.
    always_comb begin
        if (year == 7'd0) leap = (cent[1:0] == 2'b00);
        else              leap = (year[1:0] == 2'b00);
    end

    // Length table by month number.
    always_comb begin
        case (mon)
            4'd2:                    days = leap ? 5'd29 : 5'd28;
            4'd4, 4'd6, 4'd9, 4'd11: days = 5'd30;
            default:                 days = 5'd31;
        endcase
    end
endmodule

// File: rtl/cal_advance.sv
// Next-second logic: full carry chain plus the daylight-saving jumps.
// Assumes day of week 1 is Sunday; out-of-range fields wrap at their limit.
module cal_advance
    import cal_pkg::*;
#(
    parameter int SPRING_MONTH = 4,
    parameter int FALL_MONTH   = 10,
    parameter int FALL_LAST    = 31
) (
    input  cal_time_t  cur,
    input  logic [4:0] mlen,
    input  logic       dst_en,
    input  logic       fall_done,
    output cal_time_t  nxt,
    output logic       day_roll,
    output logic       year_wrap,
    output logic       fall_jump
);
    localparam int FALL_FIRST = FALL_LAST - 6;

    logic at_159, sunday, spring_jump;
    logic sec_w, min_w, hr_w, dom_w, mon_w;

    // Daylight-saving window detection.
    always_comb begin
        at_159      = (cur.hour == 7'd1) && (cur.min == 7'd59) && (cur.sec == 7'd59);
        sunday      = (cur.dow == 3'd1);
        spring_jump = dst_en && at_159 && sunday &&
                      (cur.mon == 4'(SPRING_MONTH)) && (cur.dom <= 5'd7);
        fall_jump   = dst_en && at_159 && sunday && !fall_done &&
                      (cur.mon == 4'(FALL_MONTH)) && (cur.dom >= 5'(FALL_FIRST));
    end

    // Carry chain from seconds to year.
    always_comb begin
        sec_w     = (cur.sec  >= 7'd59);
        min_w     = sec_w && (cur.min  >= 7'd59);
        hr_w      = min_w && (cur.hour >= 7'd23);
        dom_w     = hr_w  && (cur.dom  >= mlen);
        mon_w     = dom_w && (cur.mon  >= 4'd12);
        year_wrap = mon_w && (cur.year >= 7'd99);
        day_roll  = hr_w;

        nxt      = cur;
        nxt.sec  = sec_w ? 7'd0 : cur.sec + 7'd1;
        if (sec_w) nxt.min  = min_w ? 7'd0 : cur.min + 7'd1;
        if (min_w) nxt.hour = hr_w  ? 7'd0 : cur.hour + 7'd1;
        if (hr_w) begin
            nxt.dow = (cur.dow >= 3'd7) ? 3'd1 : cur.dow + 3'd1;
            nxt.dom = dom_w ? 5'd1 : cur.dom + 5'd1;
        end
        if (dom_w) nxt.mon  = mon_w ? 4'd1 : cur.mon + 4'd1;
        if (mon_w) nxt.year = year_wrap ? 7'd0 : cur.year + 7'd1;

        if (spring_jump) begin
            nxt.hour = 7'd3;
            nxt.min  = 7'd0;
            nxt.sec  = 7'd0;
        end else if (fall_jump) begin
            nxt.hour = 7'd1;
            nxt.min  = 7'd0;
            nxt.sec  = 7'd0;
        end
    end
endmodule

// File: rtl/cal_read_fmt.sv
// Read formatter: converts binary state to the host's chosen encoding.
// Assumes hours are held 0..23 in binary.
module cal_read_fmt
    import cal_pkg::*;
(
    input  logic [3:0] rd_sel,
    input  cal_time_t  t,
    input  logic [7:0] cent,
    input  logic [3:0] ctl,
    output logic [7:0] rd_data
);
    logic       fmt_bin, fmt_h24;
    logic [6:0] h12;
    logic [7:0] hour_enc;

    // Encode one field in binary or BCD.
    function automatic logic [7:0] enc(input logic [6:0] v, input logic b);
        return b ? {1'b0, v} : bin2bcd(v);
    endfunction

    // Hour encoding for 24-hour and 12-hour views.
    always_comb begin
        fmt_bin = ctl[0];
        fmt_h24 = ctl[1];
        if (t.hour == 7'd0)      h12 = 7'd12;
        else if (t.hour > 7'd12) h12 = t.hour - 7'd12;
        else                     h12 = t.hour;
        if (fmt_h24) hour_enc = enc(t.hour, fmt_bin);
        else         hour_enc = {(t.hour >= 7'd12), enc(h12, fmt_bin)[6:0]};
    end

    // Read multiplexer.
    always_comb begin
        case (rd_sel)
            SEL_SEC:  rd_data = enc(t.sec, fmt_bin);
            SEL_MIN:  rd_data = enc(t.min, fmt_bin);
            SEL_HOUR: rd_data = hour_enc;
            SEL_DOW:  rd_data = enc({4'd0, t.dow}, fmt_bin);
            SEL_DOM:  rd_data = enc({2'd0, t.dom}, fmt_bin);
            SEL_MON:  rd_data = enc({3'd0, t.mon}, fmt_bin);
            SEL_YEAR: rd_data = enc(t.year, fmt_bin);
            SEL_CENT: rd_data = cent;
            SEL_CTL:  rd_data = {4'd0, ctl};
            default:  rd_data = 8'd0;
        endcase
    end
endmodule

// File: rtl/civil_clock.sv
// Top: calendar state, host write decode, control bits and strobe handling.
// Assumes tick is a single-cycle strobe; control bits carry no reset.
module civil_clock
    import cal_pkg::*;
#(
    parameter int         SPRING_MONTH = 4,
    parameter int         FALL_MONTH   = 10,
    parameter int         FALL_LAST    = 31,
    parameter logic [7:0] RESET_CENT   = 8'h20
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tick,
    input  logic       wr_en,
    input  logic [3:0] wr_sel,
    input  logic [7:0] wr_data,
    input  logic [3:0] rd_sel,
    output logic [7:0] rd_data
);
    cal_time_t  time_q, time_nxt;
    logic [7:0] cent_q;
    logic [3:0] ctl_q;
    logic       fall_done;
    logic       ctl_bin, ctl_h24, ctl_dst, ctl_hold;
    logic       time_wr, adv;
    logic       day_roll, year_wrap, fall_jump;
    logic [4:0] mlen;
    logic [6:0] cent_dec, wr_val, h12_in, hour_in;

    // Control field split and strobe qualification.
    always_comb begin
        ctl_bin  = ctl_q[0];
        ctl_h24  = ctl_q[1];
        ctl_dst  = ctl_q[2];
        ctl_hold = ctl_q[3];
        time_wr  = wr_en && (wr_sel <= SEL_CENT);
        adv      = tick && !ctl_hold && !time_wr;
        cent_dec = ctl_bin ? cent_q[6:0] : bcd2bin({1'b0, cent_q[6:0]});
    end

    // Host write data decode into binary.
    always_comb begin
        wr_val  = ctl_bin ? wr_data[6:0] : bcd2bin(wr_data);
        h12_in  = ctl_bin ? wr_data[6:0] : bcd2bin({1'b0, wr_data[6:0]});
        if (ctl_h24) hour_in = wr_val;
        else         hour_in = ((h12_in == 7'd12) ? 7'd0 : h12_in) +
                               (wr_data[7] ? 7'd12 : 7'd0);
    end

    cal_month_len u_len (
        .mon  (time_q.mon),
        .year (time_q.year),
        .cent (cent_dec),
        .days (mlen)
    );

    cal_advance #(
        .SPRING_MONTH (SPRING_MONTH),
        .FALL_MONTH   (FALL_MONTH),
        .FALL_LAST    (FALL_LAST)
    ) u_adv (
        .cur       (time_q),
        .mlen      (mlen),
        .dst_en    (ctl_dst),
        .fall_done (fall_done),
        .nxt       (time_nxt),
        .day_roll  (day_roll),
        .year_wrap (year_wrap),
        .fall_jump (fall_jump)
    );

    cal_read_fmt u_fmt (
        .rd_sel  (rd_sel),
        .t       (time_q),
        .cent    (cent_q),
        .ctl     (ctl_q),
        .rd_data (rd_data)
    );

    // Control register: host-written only, untouched by reset.
    always_ff @(posedge clk) begin
        if (wr_en && (wr_sel == SEL_CTL)) ctl_q <= wr_data[3:0];
    end

    // Time and calendar state: reset, host write, or one-second advance.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            time_q <= '{sec: 7'd0, min: 7'd0, hour: 7'd0, dow: 3'd1,
                        dom: 5'd1, mon: 4'd1, year: 7'd0};
            cent_q <= RESET_CENT;
        end else if (time_wr) begin
            case (wr_sel)
                SEL_SEC:  time_q.sec  <= wr_val;
                SEL_MIN:  time_q.min  <= wr_val;
                SEL_HOUR: time_q.hour <= hour_in;
                SEL_DOW:  time_q.dow  <= wr_val[2:0];
                SEL_DOM:  time_q.dom  <= wr_val[4:0];
                SEL_MON:  time_q.mon  <= wr_val[3:0];
                SEL_YEAR: time_q.year <= wr_val;
                default:  cent_q      <= wr_data;
            endcase
        end else if (adv) begin
            time_q <= time_nxt;
            if (year_wrap) cent_q <= {cent_q[7], 7'h20};
        end
    end

    // One-shot autumn flag: set by the fall jump, cleared at the next day.
    always_ff @(posedge clk) begin
        if (!rst_n)                fall_done <= 1'b0;
        else if (adv && fall_jump) fall_done <= 1'b1;
        else if (adv && day_roll)  fall_done <= 1'b0;
    end
endmodule

// File: rtl/civil_clock_chk.sv
// Checker: temporal properties of the calendar counter, bound to the top.
// Assumes the internal names of civil_clock.
module civil_clock_chk
    import cal_pkg::*;
(
    input logic       clk,
    input logic       rst_n,
    input logic       wr_en,
    input logic [3:0] wr_sel,
    input logic [7:0] wr_data,
    input logic [3:0] rd_sel,
    input logic [7:0] rd_data,
    input logic       ctl_hold,
    input logic       ctl_bin,
    input logic       ctl_h24,
    input logic       time_wr,
    input logic       adv,
    input logic       year_wrap,
    input cal_time_t  time_q,
    input logic [7:0] cent_q
);
    p_hold_freeze_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_hold && !time_wr) |=> $stable(time_q));

    p_write_wins_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && (wr_sel == SEL_SEC) && ctl_bin) |=> (time_q.sec == $past(wr_data[6:0])));

    p_century_load_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (adv && year_wrap) |=> ((cent_q[6:0] == 7'h20) && (cent_q[7] == $past(cent_q[7]))));

    p_sec_moves_r4: assert property (@(posedge clk) disable iff (!rst_n)
        adv |=> !$stable(time_q.sec));

    p_hour12_nonzero_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!ctl_h24 && (rd_sel == SEL_HOUR) && (time_q.hour <= 7'd23)) |-> (rd_data[6:0] != 7'd0));
endmodule

bind civil_clock civil_clock_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (wr_en),
    .wr_sel    (wr_sel),
    .wr_data   (wr_data),
    .rd_sel    (rd_sel),
    .rd_data   (rd_data),
    .ctl_hold  (ctl_hold),
    .ctl_bin   (ctl_bin),
    .ctl_h24   (ctl_h24),
    .time_wr   (time_wr),
    .adv       (adv),
    .year_wrap (year_wrap),
    .time_q    (time_q),
    .cent_q    (cent_q)
);

// File: tb/tb_civil_clock.sv
// Bench: format sweeps, month and leap sweeps, wrap and daylight-saving cases.
module tb_civil_clock;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick = 1'b0;
    logic       wr_en = 1'b0;
    logic [3:0] wr_sel = 4'd0;
    logic [7:0] wr_data = 8'd0;
    logic [3:0] rd_sel = 4'd0;
    logic [7:0] rd_data;

    int  n_chk = 0;
    int  n_bad = 0;
    bit  done = 1'b0;
    bit  cb = 1'b1;
    bit  ch24 = 1'b1;

    civil_clock dut (
        .clk(clk), .rst_n(rst_n), .tick(tick), .wr_en(wr_en),
        .wr_sel(wr_sel), .wr_data(wr_data), .rd_sel(rd_sel), .rd_data(rd_data)
    );

    always #10 clk = ~clk;

    function automatic logic [7:0] e7(input int v);
        if (cb) return 8'(v);
        return 8'(((v / 10) << 4) | (v % 10));
    endfunction

    function automatic logic [7:0] eh(input int h);
        int h12;
        if (ch24) return e7(h);
        h12 = (h % 12 == 0) ? 12 : h % 12;
        return e7(h12) | ((h >= 12) ? 8'h80 : 8'h00);
    endfunction

    function automatic int mlen_ref(input int m, input int full_year);
        bit lp;
        lp = (full_year % 400 == 0) || ((full_year % 4 == 0) && (full_year % 100 != 0));
        if (m == 2) return lp ? 29 : 28;
        if (m == 4 || m == 6 || m == 9 || m == 11) return 30;
        return 31;
    endfunction

    task automatic wr(input logic [3:0] sel, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_sel = sel; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic mode(input bit b, input bit h, input bit dst, input bit hold);
        cb = b; ch24 = h;
        wr(4'd8, {4'd0, hold, dst, h, b});
    endtask

    task automatic tk();
        @(negedge clk);
        tick = 1'b1;
        @(negedge clk);
        tick = 1'b0;
    endtask

    task automatic chk(input logic [3:0] sel, input logic [7:0] exp, input string tag);
        rd_sel = sel;
        #1;
        n_chk++;
        if (rd_data !== exp) begin
            n_bad++;
            $display("FAIL %s sel=%0d actual=%h expected=%h", tag, sel, rd_data, exp);
        end
    endtask

    task automatic set_time(input int h, input int m, input int s);
        wr(4'd2, eh(h)); wr(4'd1, e7(m)); wr(4'd0, e7(s));
    endtask

    task automatic set_date(input int dw, input int d, input int mo, input int y, input logic [7:0] c);
        wr(4'd3, e7(dw)); wr(4'd4, e7(d)); wr(4'd5, e7(mo)); wr(4'd6, e7(y)); wr(4'd7, c);
    endtask

    task automatic chk_hms(input int h, input int m, input int s, input string tag);
        chk(4'd2, eh(h), tag); chk(4'd1, e7(m), tag); chk(4'd0, e7(s), tag);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end

    initial begin
        // R1: reset values, binary 24-hour view
        mode(1'b1, 1'b1, 1'b0, 1'b0);
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        chk_hms(0, 0, 0, "R1");
        chk(4'd3, 8'd1, "R1"); chk(4'd4, 8'd1, "R1"); chk(4'd5, 8'd1, "R1");
        chk(4'd6, 8'd0, "R1"); chk(4'd7, 8'h20, "R1");
        chk(4'd9, 8'd0, "R2 unmapped select");

        // R13: control survives reset
        mode(1'b0, 1'b0, 1'b1, 1'b1);
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk); rst_n = 1'b1;
        chk(4'd8, 8'h0C, "R13");
        chk(4'd2, 8'h92 & 8'h12, "R1 R3 midnight after reset");

        // R2 R3: hour sweep across all four formats, both directions
        for (int md = 0; md < 4; md++) begin
            for (int h = 0; h < 24; h++) begin
                mode(1'b1, 1'b1, 1'b0, 1'b0);
                wr(4'd2, 8'(h));
                mode(md[0], md[1], 1'b0, 1'b0);
                chk(4'd2, eh(h), "R3 hour read");
                wr(4'd2, eh(h));
                mode(1'b1, 1'b1, 1'b0, 1'b0);
                chk(4'd2, 8'(h), "R3 hour write");
            end
        end

        // R2 R4: BCD cascade over 100 seconds from 10:58:30
        mode(1'b0, 1'b1, 1'b0, 1'b0);
        set_date(2, 10, 3, 23, 8'h20);
        set_time(10, 58, 30);
        for (int i = 1; i <= 100; i++) begin
            int t;
            tk();
            t = 10 * 3600 + 58 * 60 + 30 + i;
            chk_hms(t / 3600, (t / 60) % 60, t % 60, "R4 R2 cascade");
        end

        // R3: 12-hour PM crossing by strobe
        mode(1'b0, 1'b0, 1'b0, 1'b0);
        set_time(11, 59, 59);
        tk();
        chk(4'd2, 8'h92, "R3 noon");

        // R5 R8: month ends in both data formats
        for (int b = 0; b < 2; b++) begin
            mode(b[0], 1'b1, 1'b0, 1'b0);
            for (int m = 1; m <= 12; m++) begin
                int len;
                len = mlen_ref(m, 2023);
                set_date(3, len - 1, m, 23, 8'h20);
                set_time(23, 59, 59);
                tk();
                chk(4'd4, e7(len), "R5 last day");
                chk(4'd3, e7(4), "R8 advance");
                set_time(23, 59, 59);
                tk();
                chk(4'd4, e7(1), "R5 first day");
                chk(4'd5, e7(m % 12 + 1), "R5 month");
                chk(4'd6, e7(m == 12 ? 24 : 23), "R5 year");
                chk_hms(0, 0, 0, "R4 midnight");
            end
        end

        // R8: day of week wrap
        mode(1'b1, 1'b1, 1'b0, 1'b0);
        set_date(7, 5, 5, 23, 8'h20);
        set_time(23, 59, 59);
        tk();
        chk(4'd3, 8'd1, "R8 wrap");

        // R6: February across leap rules, BCD century decode
        mode(1'b0, 1'b1, 1'b0, 1'b0);
        begin
            int ys[5] = '{24, 0, 0, 23, 96};
            int cs[5] = '{20, 20, 21, 20, 19};
            for (int k = 0; k < 5; k++) begin
                int fl;
                fl = cs[k] * 100 + ys[k];
                set_date(1, 28, 2, ys[k], 8'(((cs[k] / 10) << 4) | (cs[k] % 10)));
                set_time(23, 59, 59);
                tk();
                chk(4'd4, e7(mlen_ref(2, fl) == 29 ? 29 : 1), "R6 february");
            end
        end

        // R7: year wrap and century load, both MSB values
        set_date(4, 31, 12, 99, 8'h19);
        set_time(23, 59, 59);
        tk();
        chk(4'd6, 8'h00, "R7 year"); chk(4'd7, 8'h20, "R7 century");
        chk(4'd5, 8'h01, "R7 month");
        set_date(4, 31, 12, 99, 8'h99);
        set_time(23, 59, 59);
        tk();
        chk(4'd7, 8'hA0, "R7 century msb");

        // R9: spring jump inside and outside the window
        mode(1'b1, 1'b1, 1'b1, 1'b0);
        set_date(1, 7, 4, 24, 8'h20);
        set_time(1, 59, 59);
        tk();
        chk_hms(3, 0, 0, "R9 jump");
        set_date(1, 8, 4, 24, 8'h20);
        set_time(1, 59, 59);
        tk();
        chk_hms(2, 0, 0, "R9 outside window");
        mode(1'b1, 1'b1, 1'b0, 1'b0);
        set_date(1, 3, 4, 24, 8'h20);
        set_time(1, 59, 59);
        tk();
        chk_hms(2, 0, 0, "R9 disabled");

        // R10: autumn repeat hour happens once
        mode(1'b1, 1'b1, 1'b1, 1'b0);
        set_date(1, 27, 10, 24, 8'h20);
        set_time(1, 59, 59);
        tk();
        chk_hms(1, 0, 0, "R10 fall back");
        for (int i = 0; i < 3599; i++) tk();
        chk_hms(1, 59, 59, "R10 repeat hour");
        tk();
        chk_hms(2, 0, 0, "R10 once only");

        // R11: hold blocks strobes
        mode(1'b1, 1'b1, 1'b0, 1'b1);
        set_time(5, 6, 7);
        tk(); tk();
        chk_hms(5, 6, 7, "R11 hold");
        mode(1'b1, 1'b1, 1'b0, 1'b0);
        tk();
        chk(4'd0, 8'd8, "R11 release");

        // R12: write beats a same-cycle strobe
        @(negedge clk);
        wr_en = 1'b1; wr_sel = 4'd0; wr_data = 8'd40; tick = 1'b1;
        @(negedge clk);
        wr_en = 1'b0; tick = 1'b0;
        chk(4'd0, 8'd40, "R12 write wins");
        chk(4'd1, 8'd6, "R12 no carry");

        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule